// File: doc/BRIEF.md
# Redundant receiver data arbiter

This block takes one response word that has been captured at the same time by three receivers: one on the high wire of a differential bus, one on the low wire, and one on the sum of both wires. Each receiver comes with its own CRC pass flag. When the word is presented with a valid strobe, the block decides which receiver copies go into its two output data registers. It also sets an error bit and reports a three-bit code that names the fault case it found.

The decision uses the three CRC results and bit-for-bit comparisons between the receiver words. If one wire fails its CRC, the sum receiver stands in for that wire, provided the sum word agrees with the surviving wire. If both wires fail but the sum is good, the sum word is used for both registers. Any disagreement, and any case with no trusted pair of words, raises the error bit. In those cases the raw high and low words are handed on so that software can look at them.

Top module: `rx_redundant_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `dreg0`, `dreg1` and `err_flag` go to 0 and `cls_code` goes to 0.
- R2: When `hi_crc_ok` and `lo_crc_ok` are both 1, `dreg0` takes the high word and `dreg1` takes the low word, whatever `sum_crc_ok` is. `err_flag` is 1 exactly when the high and low words differ in any bit.
- R3: When the high and low CRCs both pass, `cls_code` is 0 (normal) if the sum CRC also passes, and 1 (out of spec) if the sum CRC fails.
- R4: When the high CRC passes, the low CRC fails and the sum CRC passes, `cls_code` is 2 (low wire fault). If the high word equals the sum word, the outputs are `dreg0`=high, `dreg1`=sum and `err_flag`=0. Otherwise they are high/low with `err_flag`=1.
- R5: When the low CRC passes, the high CRC fails and the sum CRC passes, `cls_code` is 3 (high wire fault). If the low word equals the sum word, the outputs are `dreg0`=sum, `dreg1`=low and `err_flag`=0. Otherwise they are high/low with `err_flag`=1.
- R6: When exactly one wire CRC passes and the sum CRC fails, `err_flag` is 1 and the outputs are high/low. `cls_code` is 2 when only the high CRC passed and 3 when only the low CRC passed.
- R7: When both wire CRCs fail and the sum CRC passes, both data registers take the sum word, `err_flag` is 0 and `cls_code` is 4 (common-mode).
- R8: When all three CRCs fail, `err_flag` is 1, the outputs are high/low and `cls_code` is 5.
- R9: All outputs change only at the clock edge that samples `in_valid` high, so new values appear one cycle after the strobe. While `in_valid` is low, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: the three words and flags are valid |
| hi_data | input | W | Word from the high-wire receiver |
| hi_crc_ok | input | 1 | CRC pass for the high-wire word |
| lo_data | input | W | Word from the low-wire receiver |
| lo_crc_ok | input | 1 | CRC pass for the low-wire word |
| sum_data | input | W | Word from the sum receiver |
| sum_crc_ok | input | 1 | CRC pass for the sum word |
| dreg0 | output | W | Output data register 0 |
| dreg1 | output | W | Output data register 1 |
| err_flag | output | 1 | Error bit |
| cls_code | output | 3 | Fault class code (0..5) |

## Verification
Two functions can act in the same cycle: substituting the sum receiver for a failed wire, and flagging a data mismatch. When a wire CRC fails but the sum word differs from the surviving wire, the substitution must be abandoned and the error raised in that same cycle. The bench provokes this by flipping a single bit of the sum word, first in the low-fault case and then in the high-fault case. It judges the result by checking that the registers carry the raw high and low words with the error bit set, while the class code still names the faulty wire.

// File: rtl/rx_arb_pkg.sv
package rx_arb_pkg;

    typedef enum logic [2:0] {
        CLS_NORMAL   = 3'd0,
        CLS_OUT_SPEC = 3'd1,
        CLS_FAULT_LO = 3'd2,
        CLS_FAULT_HI = 3'd3,
        CLS_COMMON   = 3'd4,
        CLS_ALL_FAIL = 3'd5
    } cls_e;

    typedef enum logic [1:0] {
        SRC_HI  = 2'd0,
        SRC_LO  = 2'd1,
        SRC_SUM = 2'd2
    } src_e;

    typedef struct packed {
        src_e sel0;
        src_e sel1;
        logic err;
        cls_e cls;
    } decision_t;

    function automatic decision_t make_dec(src_e s0, src_e s1, logic e, cls_e c);
        decision_t d;
        d.sel0 = s0;
        d.sel1 = s1;
        d.err  = e;
        d.cls  = c;
        return d;
    endfunction

endpackage

// File: rtl/rx_arb_cmp.sv
module rx_arb_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] hi_w,
    input  logic [W-1:0] lo_w,
    input  logic [W-1:0] sum_w,
    output logic         eq_hl,
    output logic         eq_hs,
    output logic         eq_ls
);
    logic [W-1:0] x_hl;
    logic [W-1:0] x_hs;
    logic [W-1:0] x_ls;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign x_hl[i] = hi_w[i] ^ lo_w[i];
        assign x_hs[i] = hi_w[i] ^ sum_w[i];
        assign x_ls[i] = lo_w[i] ^ sum_w[i];
    end

    assign eq_hl = ~|x_hl;
    assign eq_hs = ~|x_hs;
    assign eq_ls = ~|x_ls;
endmodule

// File: rtl/rx_arb_decide.sv
module rx_arb_decide
    import rx_arb_pkg::*;
(
    input  logic      hi_ok,
    input  logic      lo_ok,
    input  logic      sum_ok,
    input  logic      eq_hl,
    input  logic      eq_hs,
    input  logic      eq_ls,
    output decision_t dec
);
    // raw pair handed on whenever no trusted combination exists
    localparam decision_t RAW_ERR_LO = '{sel0: SRC_HI, sel1: SRC_LO, err: 1'b1, cls: CLS_FAULT_LO};
    localparam decision_t RAW_ERR_HI = '{sel0: SRC_HI, sel1: SRC_LO, err: 1'b1, cls: CLS_FAULT_HI};

    always_comb begin
        unique case ({hi_ok, lo_ok, sum_ok})
            3'b111: dec = make_dec(SRC_HI, SRC_LO, ~eq_hl, CLS_NORMAL);
            3'b110: dec = make_dec(SRC_HI, SRC_LO, ~eq_hl, CLS_OUT_SPEC);
            3'b101: dec = eq_hs ? make_dec(SRC_HI, SRC_SUM, 1'b0, CLS_FAULT_LO) : RAW_ERR_LO;
            3'b100: dec = RAW_ERR_LO;
            3'b011: dec = eq_ls ? make_dec(SRC_SUM, SRC_LO, 1'b0, CLS_FAULT_HI) : RAW_ERR_HI;
            3'b010: dec = RAW_ERR_HI;
            3'b001: dec = make_dec(SRC_SUM, SRC_SUM, 1'b0, CLS_COMMON);
            default: dec = make_dec(SRC_HI, SRC_LO, 1'b1, CLS_ALL_FAIL);
        endcase
    end
endmodule

// File: rtl/rx_arb_outreg.sv
module rx_arb_outreg
    import rx_arb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  decision_t    dec,
    input  logic [W-1:0] hi_w,
    input  logic [W-1:0] lo_w,
    input  logic [W-1:0] sum_w,
    output logic [W-1:0] q0,
    output logic [W-1:0] q1,
    output logic         q_err,
    output cls_e         q_cls
);
    logic [W-1:0] nx0;
    logic [W-1:0] nx1;

    function automatic logic [W-1:0] pick(src_e s, logic [W-1:0] h,
                                          logic [W-1:0] l, logic [W-1:0] m);
        unique case (s)
            SRC_HI:  return h;
            SRC_LO:  return l;
            SRC_SUM: return m;
            default: return h;
        endcase
    endfunction

    always_comb begin
        nx0 = pick(dec.sel0, hi_w, lo_w, sum_w);
        nx1 = pick(dec.sel1, hi_w, lo_w, sum_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q0    <= '0;
            q1    <= '0;
            q_err <= 1'b0;
            q_cls <= CLS_NORMAL;
        end else if (load) begin
            q0    <= nx0;
            q1    <= nx1;
            q_err <= dec.err;
            q_cls <= dec.cls;
        end
    end

    // R9: no strobe, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(q0) && $stable(q1) && $stable(q_err) && $stable(q_cls)));
endmodule

// File: rtl/rx_redundant_arbiter.sv
module rx_redundant_arbiter
    import rx_arb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] hi_data,
    input  logic         hi_crc_ok,
    input  logic [W-1:0] lo_data,
    input  logic         lo_crc_ok,
    input  logic [W-1:0] sum_data,
    input  logic         sum_crc_ok,
    output logic [W-1:0] dreg0,
    output logic [W-1:0] dreg1,
    output logic         err_flag,
    output logic [2:0]   cls_code
);
    logic      eq_hl;
    logic      eq_hs;
    logic      eq_ls;
    decision_t dec;
    cls_e      cls_q;

    rx_arb_cmp #(.W(W)) u_cmp (
        .hi_w  (hi_data),
        .lo_w  (lo_data),
        .sum_w (sum_data),
        .eq_hl (eq_hl),
        .eq_hs (eq_hs),
        .eq_ls (eq_ls)
    );

    rx_arb_decide u_dec (
        .hi_ok  (hi_crc_ok),
        .lo_ok  (lo_crc_ok),
        .sum_ok (sum_crc_ok),
        .eq_hl  (eq_hl),
        .eq_hs  (eq_hs),
        .eq_ls  (eq_ls),
        .dec    (dec)
    );

    rx_arb_outreg #(.W(W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .dec   (dec),
        .hi_w  (hi_data),
        .lo_w  (lo_data),
        .sum_w (sum_data),
        .q0    (dreg0),
        .q1    (dreg1),
        .q_err (err_flag),
        .q_cls (cls_q)
    );

    assign cls_code = cls_q;

    // R1: reset clears the outputs
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (dreg0 == '0 && dreg1 == '0 && !err_flag && cls_code == 3'd0));

    // R2: both wire CRCs pass, wires go straight through
    a_r2_pair: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hi_crc_ok && lo_crc_ok) |=>
        (dreg0 == $past(hi_data) && dreg1 == $past(lo_data)
         && err_flag == ($past(hi_data) != $past(lo_data))));

    // R7: common-mode, sum word in both registers
    a_r7_common: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hi_crc_ok && !lo_crc_ok && sum_crc_ok) |=>
        (dreg0 == $past(sum_data) && dreg1 == $past(sum_data) && !err_flag && cls_code == 3'd4));

    // R8: nothing passes
    a_r8_all_fail: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hi_crc_ok && !lo_crc_ok && !sum_crc_ok) |=>
        (err_flag && cls_code == 3'd5 && dreg0 == $past(hi_data) && dreg1 == $past(lo_data)));

    // R4: low-wire fault never clears error unless high agrees with sum
    a_r4_sub_lo: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hi_crc_ok && !lo_crc_ok && sum_crc_ok && hi_data != sum_data) |=>
        (err_flag && cls_code == 3'd2));
endmodule

// File: tb/tb_rx_redundant_arbiter.sv
module tb_rx_redundant_arbiter;
    localparam int W = 16;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [W-1:0] hi_data, lo_data, sum_data;
    logic         hi_crc_ok, lo_crc_ok, sum_crc_ok;
    logic [W-1:0] dreg0, dreg1;
    logic         err_flag;
    logic [2:0]   cls_code;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_redundant_arbiter #(.W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .hi_data(hi_data), .hi_crc_ok(hi_crc_ok),
        .lo_data(lo_data), .lo_crc_ok(lo_crc_ok),
        .sum_data(sum_data), .sum_crc_ok(sum_crc_ok),
        .dreg0(dreg0), .dreg1(dreg1), .err_flag(err_flag), .cls_code(cls_code)
    );

    task automatic chk(string req, logic [W-1:0] e0, logic [W-1:0] e1, logic ee, logic [2:0] ec);
        checks++;
        if (dreg0 !== e0 || dreg1 !== e1 || err_flag !== ee || cls_code !== ec) begin
            failures++;
            $display("FAIL %s: got d0=%h d1=%h err=%b cls=%0d expected d0=%h d1=%h err=%b cls=%0d",
                     req, dreg0, dreg1, err_flag, cls_code, e0, e1, ee, ec);
        end
    endtask

    // drive at falling edge, strobe for one cycle, result visible at next falling edge
    task automatic apply(logic [W-1:0] h, logic hok, logic [W-1:0] l, logic lok,
                         logic [W-1:0] s, logic sok);
        @(negedge clk);
        hi_data = h; hi_crc_ok = hok;
        lo_data = l; lo_crc_ok = lok;
        sum_data = s; sum_crc_ok = sok;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        apply(16'hAAAA, 1, 16'h5555, 1, 16'h1234, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset", 16'h0000, 16'h0000, 1'b0, 3'd0);
    endtask

    task automatic t_both_pass();
        apply(16'hC3A5, 1, 16'hC3A5, 1, 16'h0F0F, 1);
        chk("R2/R3 normal match", 16'hC3A5, 16'hC3A5, 1'b0, 3'd0);
        apply(16'hC3A5, 1, 16'hC3A4, 1, 16'hC3A5, 1);
        chk("R2 normal mismatch", 16'hC3A5, 16'hC3A4, 1'b1, 3'd0);
        apply(16'h7E01, 1, 16'h7E01, 1, 16'hFFFF, 0);
        chk("R3 out-of-spec match", 16'h7E01, 16'h7E01, 1'b0, 3'd1);
        apply(16'h8000, 1, 16'h0000, 1, 16'h8000, 0);
        chk("R3 out-of-spec msb mismatch", 16'h8000, 16'h0000, 1'b1, 3'd1);
    endtask

    task automatic t_fault_low();
        apply(16'h1357, 1, 16'hDEAD, 0, 16'h1357, 1);
        chk("R4 low fault substitute", 16'h1357, 16'h1357, 1'b0, 3'd2);
        apply(16'h2468, 1, 16'hBEEF, 0, 16'h2469, 1);
        chk("R4 low fault sum mismatch", 16'h2468, 16'hBEEF, 1'b1, 3'd2);
    endtask

    task automatic t_fault_high();
        apply(16'hF00D, 0, 16'h9ABC, 1, 16'h9ABC, 1);
        chk("R5 high fault substitute", 16'h9ABC, 16'h9ABC, 1'b0, 3'd3);
        apply(16'hF00D, 0, 16'h9ABC, 1, 16'h1ABC, 1);
        chk("R5 high fault sum mismatch", 16'hF00D, 16'h9ABC, 1'b1, 3'd3);
    endtask

    task automatic t_single_wire();
        apply(16'h4444, 1, 16'h4444, 0, 16'h4444, 0);
        chk("R6 only high passes", 16'h4444, 16'h4444, 1'b1, 3'd2);
        apply(16'h1111, 0, 16'h2222, 1, 16'h2222, 0);
        chk("R6 only low passes", 16'h1111, 16'h2222, 1'b1, 3'd3);
    endtask

    task automatic t_common();
        apply(16'h0101, 0, 16'h0202, 0, 16'h6789, 1);
        chk("R7 common-mode", 16'h6789, 16'h6789, 1'b0, 3'd4);
    endtask

    task automatic t_all_fail();
        apply(16'hABCD, 0, 16'hABCD, 0, 16'hABCD, 0);
        chk("R8 all fail", 16'hABCD, 16'hABCD, 1'b1, 3'd5);
    endtask

    task automatic t_hold();
        apply(16'h0F0F, 0, 16'hF0F0, 0, 16'h3C3C, 1);
        chk("R9 load", 16'h3C3C, 16'h3C3C, 1'b0, 3'd4);
        hi_data = 16'h1111; lo_data = 16'h2222; sum_data = 16'h3333;
        hi_crc_ok = 1; lo_crc_ok = 0; sum_crc_ok = 0;
        repeat (3) @(negedge clk);
        chk("R9 hold without strobe", 16'h3C3C, 16'h3C3C, 1'b0, 3'd4);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0;
        hi_data = '0; lo_data = '0; sum_data = '0;
        hi_crc_ok = 0; lo_crc_ok = 0; sum_crc_ok = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 after power-up reset", 16'h0000, 16'h0000, 1'b0, 3'd0);
        t_both_pass();
        t_fault_low();
        t_fault_high();
        t_single_wire();
        t_common();
        t_all_fail();
        t_hold();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule